// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block guards a small shared word-addressed memory used by several requesting agents. An agent can issue a plain load, a plain store, an exclusive load, an exclusive store or a clear-reservation command. A fixed-priority arbiter accepts one request per cycle. The monitor holds at most one reservation per agent, made of a held flag and a word address. An exclusive store writes only when the requester still holds a reservation on the same word. Because any store by any agent to a reserved word removes that reservation, a read, test and conditional write sequence on a lock word works without locking the bus.

Each agent's reservation is a two-state machine. In `RSV_IDLE` there is no reservation. The `TAKE` transition goes from `RSV_IDLE` to `RSV_HELD` when the agent's exclusive load is accepted. In `RSV_HELD` the slot takes `RETAKE`, staying in `RSV_HELD` with a new address, on another exclusive load by the same agent. It takes `RELEASE` to `RSV_IDLE` on its own exclusive store or clear command. It takes `SNOOP_KILL` to `RSV_IDLE` when any committed write hits the held address. In every other case the slot holds its state.

Every accepted request gets a response one cycle later. A load returns data. An exclusive store returns a status word. A plain store or a clear command returns zero. Operation codes: 0 load, 1 store, 2 exclusive load, 3 exclusive store, 4 clear reservation. Codes 5 to 7 behave as plain loads.

Top module: `excl_monitor`

## Requirements
- R1: After reset no agent holds a reservation, every memory word reads 0, `rsp_valid` is 0 and `rsp_data` is 0.
- R2: Each cycle `req_ready` is high for exactly the lowest-numbered agent with `req_valid` high and low for all others. A waiting agent keeps its request until it is served.
- R3: A request accepted in cycle t produces `rsp_valid` set for that agent only in cycle t+1. A load (code 0) returns the word's current value. A plain store (code 1) always writes and returns 0.
- R4: An exclusive load (code 2) returns the addressed word and reserves that address for the requester.
- R5: An exclusive store (code 3) to the address the requester holds reserved writes the data and returns status 0.
- R6: An exclusive store with no reservation, or with a reservation on a different address, leaves memory unchanged and returns status 1.
- R7: The requester's reservation is gone after any exclusive store, whether it succeeded or failed.
- R8: A committed write (a plain store or a successful exclusive store) by any agent clears, in the same cycle, every reservation on that address. Reservations on other addresses are kept.
- R9: A clear command (code 4) removes only the requester's reservation, leaves memory unchanged and returns 0.
- R10: A new exclusive load replaces the requester's earlier reservation.
- R11: When two agents that both reserved a lock word present exclusive stores to it in the same cycle, only the lower-numbered agent succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_AGENTS | Request present, one bit per agent |
| req_op | input | 3*N_AGENTS | Operation code per agent |
| req_addr | input | ADDR_W*N_AGENTS | Word address per agent |
| req_wdata | input | DATA_W*N_AGENTS | Store data per agent |
| req_ready | output | N_AGENTS | Grant: request accepted this cycle |
| rsp_valid | output | N_AGENTS | One-hot: response for that agent this cycle |
| rsp_data | output | DATA_W | Load data, exclusive-store status, or 0 |

## Verification
The case that matters is one agent's store hitting a word while another agent's exclusive store to that word waits behind it. The store's write and the snoop that kills the waiting agent's reservation then happen in the same cycle. The bench provokes this by driving two agents in the same cycle, both in directed lock contention and in a swept series of random operation pairs on four hot addresses. The lower agent is served first, and the waiting agent's status is compared against an arithmetic model that applies the two operations in priority order.

// File: rtl/excl_pkg.sv
package excl_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LDEX  = 3'd2,
        OP_STEX  = 3'd3,
        OP_CLREX = 3'd4
    } op_e;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

    localparam int unsigned STAT_OK   = 0;
    localparam int unsigned STAT_FAIL = 1;

endpackage

// File: rtl/excl_arbiter.sv
module excl_arbiter #(
    parameter int N_AGENTS = 3,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [N_AGENTS-1:0] valid,
    output logic [N_AGENTS-1:0] grant,
    output logic [IDX_W-1:0]    gnt_idx,
    output logic                gnt_any
);
    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        grant   = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (valid[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                gnt_idx  = IDX_W'(i);
                gnt_any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/excl_mem.sv
module excl_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/excl_rsv_slot.sv
module excl_rsv_slot
    import excl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_gnt,
    input  op_e               own_op,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              held,
    output logic [ADDR_W-1:0] rsv_addr
);
    rsv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RSV_IDLE: begin
                if (own_gnt && own_op == OP_LDEX) begin   // TAKE
                    state_d = RSV_HELD;
                    addr_d  = own_addr;
                end
            end
            RSV_HELD: begin
                if (own_gnt && own_op == OP_LDEX) begin   // RETAKE
                    addr_d = own_addr;
                end else if (own_gnt && (own_op == OP_STEX || own_op == OP_CLREX)) begin
                    state_d = RSV_IDLE;                   // RELEASE
                end else if (wr_en && wr_addr == addr_q) begin
                    state_d = RSV_IDLE;                   // SNOOP_KILL
                end
            end
            default: state_d = RSV_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // outputs
    always_comb begin
        held     = (state_q == RSV_HELD);
        rsv_addr = addr_q;
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_pkg::*;
#(
    parameter int N_AGENTS = 3,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_AGENTS-1:0]          req_valid,
    input  logic [3*N_AGENTS-1:0]        req_op,
    input  logic [ADDR_W*N_AGENTS-1:0]   req_addr,
    input  logic [DATA_W*N_AGENTS-1:0]   req_wdata,
    output logic [N_AGENTS-1:0]          req_ready,
    output logic [N_AGENTS-1:0]          rsp_valid,
    output logic [DATA_W-1:0]            rsp_data
);
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

    op_e               op_a    [N_AGENTS];
    logic [ADDR_W-1:0] addr_a  [N_AGENTS];
    logic [DATA_W-1:0] wdata_a [N_AGENTS];
    logic [ADDR_W-1:0] rsv_addr_a [N_AGENTS];
    logic [N_AGENTS-1:0]        held;
    logic [ADDR_W*N_AGENTS-1:0] rsv_addr_flat;

    logic [N_AGENTS-1:0] grant;
    logic [IDX_W-1:0]    gnt_idx;
    logic                gnt_any;
    op_e                 gnt_op;
    logic [ADDR_W-1:0]   gnt_addr;
    logic [DATA_W-1:0]   gnt_wdata;

    logic              stex_ok;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] rsp_data_d;

    logic [N_AGENTS-1:0] rsp_valid_q;
    logic [DATA_W-1:0]   rsp_data_q;

    excl_arbiter #(.N_AGENTS(N_AGENTS)) u_arb (
        .valid   (req_valid),
        .grant   (grant),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        assign op_a[g]    = op_e'(req_op[3*g +: 3]);
        assign addr_a[g]  = req_addr[ADDR_W*g +: ADDR_W];
        assign wdata_a[g] = req_wdata[DATA_W*g +: DATA_W];

        excl_rsv_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .own_gnt  (grant[g]),
            .own_op   (op_a[g]),
            .own_addr (addr_a[g]),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .held     (held[g]),
            .rsv_addr (rsv_addr_a[g])
        );

        assign rsv_addr_flat[ADDR_W*g +: ADDR_W] = rsv_addr_a[g];
    end

    // granted request mux
    always_comb begin
        gnt_op    = op_a[gnt_idx];
        gnt_addr  = addr_a[gnt_idx];
        gnt_wdata = wdata_a[gnt_idx];
    end

    // commit decision for the granted request
    always_comb begin
        stex_ok    = held[gnt_idx] && (rsv_addr_a[gnt_idx] == gnt_addr);
        wr_en      = 1'b0;
        rsp_data_d = '0;
        unique case (gnt_op)
            OP_STORE: wr_en = gnt_any;
            OP_STEX: begin
                wr_en      = gnt_any && stex_ok;
                rsp_data_d = stex_ok ? DATA_W'(STAT_OK) : DATA_W'(STAT_FAIL);
            end
            OP_CLREX: rsp_data_d = '0;
            default:  rsp_data_d = mem_rdata;   // loads and unused codes
        endcase
    end

    assign wr_addr = gnt_addr;

    excl_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (gnt_wdata),
        .raddr (gnt_addr),
        .rdata (mem_rdata)
    );

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= '0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= grant;
            if (gnt_any) rsp_data_q <= rsp_data_d;
        end
    end

    assign req_ready = grant;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk
    import excl_pkg::*;
#(
    parameter int N_AGENTS = 3,
    parameter int ADDR_W   = 4,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_AGENTS-1:0]        req_valid,
    input logic [N_AGENTS-1:0]        req_ready,
    input logic [N_AGENTS-1:0]        rsp_valid,
    input logic                       gnt_any,
    input logic [IDX_W-1:0]           gnt_idx,
    input op_e                        gnt_op,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [N_AGENTS-1:0]        held,
    input logic [ADDR_W*N_AGENTS-1:0] rsv_addr_flat
);
    // R2
    ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    // R2
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    // R2
    lowest_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid != '0) |-> (req_ready == (req_valid & (~req_valid + 1'b1))));

    // R3
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready != '0 |=> rsp_valid == $past(req_ready));

    // R3
    write_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (gnt_any && (gnt_op == OP_STORE || gnt_op == OP_STEX)));

    // R6
    stex_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && gnt_op == OP_STEX && !held[gnt_idx]) |-> !wr_en);

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_slot
        // R7
        stex_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_any && gnt_idx == IDX_W'(i) && gnt_op == OP_STEX) |=> !held[i]);

        // R8
        store_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && held[i] && rsv_addr_flat[ADDR_W*i +: ADDR_W] == wr_addr) |=> !held[i]);
    end
endmodule

bind excl_monitor excl_monitor_chk #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .gnt_any       (gnt_any),
    .gnt_idx       (gnt_idx),
    .gnt_op        (gnt_op),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .held          (held),
    .rsv_addr_flat (rsv_addr_flat)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
    localparam int N = 3;
    localparam int AW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [3*N-1:0]  req_op = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]    req_ready;
    logic [N-1:0]    rsp_valid;
    logic [DW-1:0]   rsp_data;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    excl_monitor #(.N_AGENTS(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // reference model
    logic [DW-1:0] m_mem [16];
    bit            m_held [N];
    logic [AW-1:0] m_addr [N];

    function automatic void m_write(logic [AW-1:0] a, logic [DW-1:0] d);
        m_mem[a] = d;
        for (int j = 0; j < N; j++) if (m_held[j] && m_addr[j] == a) m_held[j] = 0;
    endfunction

    function automatic logic [DW-1:0] m_step(int ag, logic [2:0] op, logic [AW-1:0] a,
                                             logic [DW-1:0] d, output string tag);
        logic [DW-1:0] r = '0;
        case (op)
            3'd1: begin m_write(a, d); tag = "R3"; end
            3'd2: begin r = m_mem[a]; m_held[ag] = 1; m_addr[ag] = a; tag = "R4"; end
            3'd3: begin
                if (m_held[ag] && m_addr[ag] == a) begin m_write(a, d); tag = "R5"; end
                else begin r = 1; tag = "R6"; end
                m_held[ag] = 0;
            end
            3'd4: begin m_held[ag] = 0; tag = "R9"; end
            default: begin r = m_mem[a]; tag = "R3"; end
        endcase
        return r;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(int ag, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
        req_valid[ag]          = 1'b1;
        req_op[3*ag +: 3]      = op;
        req_addr[AW*ag +: AW]  = a;
        req_wdata[DW*ag +: DW] = d;
    endtask

    task automatic do_op(int ag, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                         output logic [DW-1:0] got);
        string tag;
        logic [DW-1:0] exp;
        @(negedge clk);
        drive(ag, op, a, d);
        #1;
        check(req_ready == N'(1 << ag), "R2", "ready", req_ready, N'(1 << ag));
        exp = m_step(ag, op, a, d, tag);
        @(negedge clk);
        req_valid = '0;
        check(rsp_valid == N'(1 << ag), "R3", "rsp_valid", rsp_valid, N'(1 << ag));
        check(rsp_data == exp, tag, "rsp_data", rsp_data, exp);
        got = rsp_data;
    endtask

    // two agents in the same cycle, a < b
    task automatic do_pair(int a, logic [2:0] opa, logic [AW-1:0] aa, logic [DW-1:0] da,
                           int b, logic [2:0] opb, logic [AW-1:0] ab, logic [DW-1:0] db,
                           string tg, output logic [DW-1:0] ga, output logic [DW-1:0] gb);
        string t1, t2;
        logic [DW-1:0] ea, eb;
        @(negedge clk);
        drive(a, opa, aa, da);
        drive(b, opb, ab, db);
        #1;
        check(req_ready == N'(1 << a), "R2", "pair first ready", req_ready, N'(1 << a));
        ea = m_step(a, opa, aa, da, t1);
        @(negedge clk);
        req_valid[a] = 1'b0;
        check(rsp_valid == N'(1 << a), "R3", "pair first rsp", rsp_valid, N'(1 << a));
        check(rsp_data == ea, tg, "pair first data", rsp_data, ea);
        ga = rsp_data;
        #1;
        check(req_ready == N'(1 << b), "R2", "pair second ready", req_ready, N'(1 << b));
        eb = m_step(b, opb, ab, db, t2);
        @(negedge clk);
        req_valid[b] = 1'b0;
        check(rsp_valid == N'(1 << b), "R3", "pair second rsp", rsp_valid, N'(1 << b));
        check(rsp_data == eb, tg, "pair second data", rsp_data, eb);
        gb = rsp_data;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r, r2;
        logic [31:0] lfsr = 32'hACE1_1234;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        for (int i = 0; i < N; i++) begin m_held[i] = 0; m_addr[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(rsp_valid == '0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(rsp_data == '0, "R1", "rsp_data after reset", rsp_data, 0);
        check(req_ready == '0, "R1", "ready idle", req_ready, 0);
        do_op(2, 3'd3, 4'd5, 16'hBEEF, r);
        check(r == 1, "R1", "no reservation after reset", r, 1);
        do_op(0, 3'd0, 4'd5, 0, r);
        check(r == 0, "R1", "memory zero after reset", r, 0);

        // R4 / R5
        do_op(1, 3'd2, 4'd3, 0, r);
        do_op(1, 3'd3, 4'd3, 16'h1111, r);
        check(r == 0, "R5", "stex with reservation", r, 0);
        do_op(0, 3'd0, 4'd3, 0, r);
        check(r == 16'h1111, "R5", "stex data written", r, 16'h1111);
        // R7
        do_op(1, 3'd3, 4'd3, 16'h2222, r);
        check(r == 1, "R7", "second stex fails", r, 1);
        // R6 wrong address, then R7 after failed stex
        do_op(1, 3'd2, 4'd3, 0, r);
        do_op(1, 3'd3, 4'd4, 16'h3333, r);
        check(r == 1, "R6", "stex other address", r, 1);
        do_op(1, 3'd3, 4'd3, 16'h3333, r);
        check(r == 1, "R7", "reservation gone after failed stex", r, 1);
        do_op(0, 3'd0, 4'd4, 0, r);
        check(r == 0, "R6", "memory unchanged", r, 0);
        // R8
        do_op(0, 3'd2, 4'd6, 0, r);
        do_op(2, 3'd2, 4'd6, 0, r);
        do_op(1, 3'd1, 4'd7, 16'h7777, r);
        do_op(0, 3'd3, 4'd6, 16'h6666, r);
        check(r == 0, "R8", "store elsewhere keeps reservation", r, 0);
        do_op(2, 3'd3, 4'd6, 16'h6667, r);
        check(r == 1, "R8", "exclusive store kills other", r, 1);
        do_op(2, 3'd2, 4'd8, 0, r);
        do_op(1, 3'd1, 4'd8, 16'h8888, r);
        do_op(2, 3'd3, 4'd8, 16'h8889, r);
        check(r == 1, "R8", "plain store kills reservation", r, 1);
        // R9
        do_op(0, 3'd2, 4'd9, 0, r);
        do_op(1, 3'd2, 4'd9, 0, r);
        do_op(0, 3'd4, 4'd9, 16'hFFFF, r);
        check(r == 0, "R9", "clear status", r, 0);
        do_op(1, 3'd3, 4'd9, 16'h9999, r);
        check(r == 0, "R9", "other agent kept reservation", r, 0);
        do_op(0, 3'd3, 4'd9, 16'h9998, r);
        check(r == 1, "R9", "own reservation cleared", r, 1);
        do_op(2, 3'd0, 4'd9, 0, r);
        check(r == 16'h9999, "R9", "clear left memory", r, 16'h9999);
        // R10
        do_op(2, 3'd2, 4'd10, 0, r);
        do_op(2, 3'd2, 4'd11, 0, r);
        do_op(2, 3'd3, 4'd10, 16'hAAAA, r);
        check(r == 1, "R10", "old reservation replaced", r, 1);
        do_op(2, 3'd2, 4'd10, 0, r);
        do_op(2, 3'd2, 4'd11, 0, r);
        do_op(2, 3'd3, 4'd11, 16'hBBBB, r);
        check(r == 0, "R10", "new reservation used", r, 0);

        // R11 lock contention on word 12
        do_pair(0, 3'd2, 4'd12, 0, 1, 3'd2, 4'd12, 0, "R11", r, r2);
        check(r == 0 && r2 == 0, "R11", "both see lock free", {r, r2}, 0);
        do_pair(0, 3'd3, 4'd12, 16'd1, 1, 3'd3, 4'd12, 16'd2, "R11", r, r2);
        check(r == 0, "R11", "lower agent acquires", r, 0);
        check(r2 == 1, "R11", "higher agent refused", r2, 1);
        do_op(2, 3'd0, 4'd12, 0, r);
        check(r == 1, "R11", "lock owner value", r, 1);
        do_pair(1, 3'd2, 4'd13, 0, 2, 3'd2, 4'd13, 0, "R11", r, r2);
        do_pair(1, 3'd3, 4'd13, 16'd5, 2, 3'd3, 4'd13, 16'd6, "R11", r, r2);
        check(r == 0 && r2 == 1, "R11", "agents 1 and 2 contend", {r, r2}, 1);

        // sweep: single operations on hot addresses
        for (int k = 0; k < 900; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            do_op(int'(lfsr[3:0]) % N, 3'(int'(lfsr[9:6]) % 5), AW'(lfsr[12:11]),
                  lfsr[31:16], r);
        end
        // sweep: contending pairs (R8 snoop in the same cycle as a waiting stex)
        for (int k = 0; k < 300; k++) begin
            int a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = int'(lfsr[1:0]) % 2;
            b = a + 1 + (int'(lfsr[2]) % (N - 1 - a));
            do_pair(a, 3'(int'(lfsr[7:4]) % 5), AW'(lfsr[9:8]), lfsr[31:16],
                    b, 3'(int'(lfsr[13:10]) % 5), AW'(lfsr[15:14]), lfsr[27:12],
                    "R8", r, r2);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule